// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches a group of general-purpose input pins and turns selected events on them into interrupt requests. Each pin first passes through a two-flop synchronizer. A per-pin detector then looks for a rising edge, a falling edge, either edge, a high level or a low level. Three configuration words choose the event for each pin. The detector's result is the pin's raw status bit. A per-pin mask gates the raw status into a masked status word, and the OR of that word drives one registered interrupt line.

Software reaches the configuration through a small word-wide register bus with one write strobe and a combinational read port. The bus exposes four configuration words: the sense select, the both-edges select, the polarity select and the mask. It also has a write-1-to-clear word for latched edge events, and read-only views of the raw and masked status. Edge events stay latched until software clears them. Level events follow the synchronized pin and have no memory.

Top module: `pin_event_irq`

## Requirements
- R1: A pin change is seen by the detectors two clock edges after it is applied: a level-mode raw status bit changes at the second rising edge, and an edge-mode raw status bit sets at the third.
- R2: With its sense bit at 1 (level mode), a pin's raw status is 1 while the synchronized pin equals its polarity bit (1 = high, 0 = low). It is not latched, and a clear write leaves it unchanged.
- R3: With its sense bit at 0 and its both-edges bit at 0, a pin's raw status sets on a rising edge when its polarity bit is 1 and on a falling edge when it is 0. It stays set after the pin returns.
- R4: With its sense bit at 0 and its both-edges bit at 1, a pin's raw status sets on either edge whatever its polarity bit holds. In level mode the both-edges bit has no effect.
- R5: Writing the clear word (address 4) clears the latched edge status of each pin whose data bit is 1 and leaves the pins written with 0 unchanged. A new edge that lands in the same cycle as the clear keeps the bit set.
- R6: While reset is low, the sense, both-edges, polarity and mask words, the raw and masked status and the interrupt output are all 0.
- R7: The masked status is the raw status ANDed with the mask word, where a mask bit of 1 enables that pin. The interrupt output is the OR of the masked status, registered, so it follows one clock edge later.
- R8: The register map is: 0 sense, 1 both-edges, 2 polarity, 3 mask, 4 clear (reads 0), 5 raw status (read-only), 6 masked status (read-only), 7 reads 0. Reads are combinational from the address, and writes take effect at the rising edge where the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | 8 | Asynchronous pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| raw_stat | output | 8 | Raw status per pin |
| masked_stat | output | 8 | Raw status gated by the mask |
| irq_out | output | 1 | Registered OR of the masked status |

## Verification
Inputs are driven on the falling clock edge. Each result is then sampled on a later falling edge, at the point where it is due. A pin change is checked in level mode after two falling edges and in edge mode after three, and the interrupt line is checked one edge after that. At each of these points the bench also checks the value one edge earlier, to pin the latency exactly. A register write takes effect at the rising edge inside the bus task, so configuration and clear results are read back on the falling edge right after the task returns. The same-cycle race is set up by starting the clear write exactly two falling edges after the pin change, so that the write strobe and the latching edge meet at the same rising edge.

// File: rtl/pin_irq_pkg.sv
// Shared definitions for the pin event interrupt detector.
// Assumes a register bus with at most eight word addresses.
package pin_irq_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_SENSE  = 3'd0,
        RA_BOTH   = 3'd1,
        RA_POL    = 3'd2,
        RA_MASK   = 3'd3,
        RA_CLEAR  = 3'd4,
        RA_RAW    = 3'd5,
        RA_MASKED = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is unrelated to the others (no bus coherency is given).
module pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
// Configuration register file with a write-1-to-clear pulse and a read mux.
// Assumes single-cycle writes; the clear word is not stored, only pulsed.
module irq_cfg_regs
    import pin_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]      wdata,
    input  logic [WIDTH-1:0]      raw_in,
    input  logic [WIDTH-1:0]      masked_in,
    output logic [WIDTH-1:0]      rdata,
    output logic [WIDTH-1:0]      sense,
    output logic [WIDTH-1:0]      both,
    output logic [WIDTH-1:0]      pol,
    output logic [WIDTH-1:0]      mask,
    output logic [WIDTH-1:0]      clr_pulse
);
    // Update the four configuration words on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense <= '0;
            both  <= '0;
            pol   <= '0;
            mask  <= '0;
        end else if (we) begin
            case (addr)
                RA_SENSE: sense <= wdata;
                RA_BOTH:  both  <= wdata;
                RA_POL:   pol   <= wdata;
                RA_MASK:  mask  <= wdata;
                default:  ;
            endcase
        end
    end

    // Clear pulse is live only during the cycle of a clear-word write.
    always_comb begin
        clr_pulse = '0;
        if (we && addr == RA_CLEAR) clr_pulse = wdata;
    end

    // Combinational read selection.
    always_comb begin
        case (addr)
            RA_SENSE:  rdata = sense;
            RA_BOTH:   rdata = both;
            RA_POL:    rdata = pol;
            RA_MASK:   rdata = mask;
            RA_RAW:    rdata = raw_in;
            RA_MASKED: rdata = masked_in;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_event_cell.sv
// Per-pin event detector: level compare or latched edge detection.
// Assumes a synchronized input; edges are found against the prior sample.
module pin_event_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    input  logic sense_lvl,
    input  logic both_edge,
    input  logic pol_hi,
    input  logic clr,
    output logic raw
);
    logic prev_q;
    logic edge_q;
    logic rise;
    logic fall;
    logic hit;

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync;
    end

    // Pick which transition counts as an event.
    always_comb begin
        rise = pin_sync & ~prev_q;
        fall = ~pin_sync & prev_q;
        if (both_edge) hit = rise | fall;
        else           hit = pol_hi ? rise : fall;
    end

    // Edge latch: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                edge_q <= 1'b0;
        else if (hit && !sense_lvl) edge_q <= 1'b1;
        else if (clr)              edge_q <= 1'b0;
    end

    // Level mode compares live; edge mode reports the latch.
    always_comb begin
        if (sense_lvl) raw = (pin_sync == pol_hi);
        else           raw = edge_q;
    end
endmodule

// File: rtl/pin_event_irq.sv
// Top level: synchronizer, config registers, per-pin detectors, interrupt.
// Assumes pins_in is held low during reset to avoid a spurious first edge.
module pin_event_irq
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins_in,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [NUM_PINS-1:0]   reg_wdata,
    output logic [NUM_PINS-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0]   raw_stat,
    output logic [NUM_PINS-1:0]   masked_stat,
    output logic                  irq_out
);
    logic [NUM_PINS-1:0] sync_pins;
    logic [NUM_PINS-1:0] cfg_sense;
    logic [NUM_PINS-1:0] cfg_both;
    logic [NUM_PINS-1:0] cfg_pol;
    logic [NUM_PINS-1:0] cfg_mask;
    logic [NUM_PINS-1:0] clr_pulse;

    pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_in),
        .sync_out (sync_pins)
    );

    irq_cfg_regs #(.WIDTH(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .raw_in    (raw_stat),
        .masked_in (masked_stat),
        .rdata     (reg_rdata),
        .sense     (cfg_sense),
        .both      (cfg_both),
        .pol       (cfg_pol),
        .mask      (cfg_mask),
        .clr_pulse (clr_pulse)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            pin_event_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_sync  (sync_pins[p]),
                .sense_lvl (cfg_sense[p]),
                .both_edge (cfg_both[p]),
                .pol_hi    (cfg_pol[p]),
                .clr       (clr_pulse[p]),
                .raw       (raw_stat[p])
            );
        end
    endgenerate

    assign masked_stat = raw_stat & cfg_mask;

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |masked_stat;
    end
endmodule

// File: rtl/pin_event_irq_checker.sv
// Property checker for pin_event_irq, attached by bind.
// Assumes it observes internal configuration and synchronized pin nets.
module pin_event_irq_checker
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pins_in,
    input logic [NUM_PINS-1:0]   sync_pins,
    input logic [NUM_PINS-1:0]   cfg_sense,
    input logic [NUM_PINS-1:0]   cfg_both,
    input logic [NUM_PINS-1:0]   cfg_pol,
    input logic [NUM_PINS-1:0]   cfg_mask,
    input logic                  reg_we,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [NUM_PINS-1:0]   reg_wdata,
    input logic [NUM_PINS-1:0]   raw_stat,
    input logic [NUM_PINS-1:0]   masked_stat,
    input logic                  irq_out
);
    logic [1:0] since_rst;

    // Count cycles since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_cfg_reset_r6: assert property (@(posedge clk)
        !rst_n |=> (cfg_sense == '0 && cfg_both == '0 && cfg_pol == '0
                    && cfg_mask == '0 && !irq_out));

    p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (sync_pins == $past(pins_in, 2)));

    p_irq_registered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) |-> (irq_out == $past(|masked_stat)));

    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_bit
            p_edge_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst != 2'd0 && !cfg_sense[i] && $past(!cfg_sense[i])
                 && $past(raw_stat[i])
                 && !$past(reg_we && reg_addr == RA_CLEAR && reg_wdata[i]))
                |-> raw_stat[i]);

            p_level_ignores_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst != 2'd0 && cfg_sense[i] && $past(cfg_sense[i])
                 && $stable(sync_pins[i]) && $stable(cfg_pol[i]))
                |-> $stable(raw_stat[i]));

            p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg_mask[i] |-> !masked_stat[i]);
        end
    endgenerate
endmodule

bind pin_event_irq pin_event_irq_checker #(.NUM_PINS(NUM_PINS)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_in     (pins_in),
    .sync_pins   (sync_pins),
    .cfg_sense   (cfg_sense),
    .cfg_both    (cfg_both),
    .cfg_pol     (cfg_pol),
    .cfg_mask    (cfg_mask),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .raw_stat    (raw_stat),
    .masked_stat (masked_stat),
    .irq_out     (irq_out)
);

// File: tb/pin_event_irq_tb.sv
// Directed bench for pin_event_irq: one task per scenario.
module pin_event_irq_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pins_in = '0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] raw_stat;
    logic [W-1:0] masked_stat;
    logic         irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pin_event_irq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_in     (pins_in),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .raw_stat    (raw_stat),
        .masked_stat (masked_stat),
        .irq_out     (irq_out)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Write lands at the rising edge between the two falling edges.
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v);
            chk("R6 config word zero after reset", v, '0);
        end
        chk("R6 raw zero", raw_stat, '0);
        chk("R6 masked zero", masked_stat, '0);
        chk("R6 irq zero", {7'd0, irq_out}, '0);
    endtask

    task automatic t_level;
        logic [W-1:0] v;
        wr(3'd0, 8'hFF);
        wr(3'd2, 8'h0F);
        wr(3'd3, 8'hFF);
        rd(3'd0, v);
        chk("R8 sense readback", v, 8'hFF);
        chk("R2 level compare pins low", raw_stat, 8'hF0);
        pins_in = 8'hFF;
        idle(1);
        chk("R1 level not yet changed after one edge", raw_stat, 8'hF0);
        idle(1);
        chk("R1 R2 level after two edges", raw_stat, 8'h0F);
        wr(3'd4, 8'hFF);
        chk("R2 clear has no effect in level mode", raw_stat, 8'h0F);
        chk("R7 irq set", {7'd0, irq_out}, 8'h01);
        wr(3'd3, 8'h00);
        chk("R7 masked zero with mask off", masked_stat, '0);
        idle(1);
        chk("R7 irq drops one edge later", {7'd0, irq_out}, '0);
        pins_in = 8'h00;
        idle(4);
    endtask

    task automatic t_edge_rise_fall;
        logic [W-1:0] v;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hFD);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        chk("R3 edge status starts clear", raw_stat, '0);
        pins_in = 8'h03;
        idle(2);
        chk("R1 edge not yet latched after two edges", raw_stat, '0);
        idle(1);
        chk("R1 R3 rising edge latched bit0 only", raw_stat, 8'h01);
        chk("R7 irq not yet", {7'd0, irq_out}, '0);
        idle(1);
        chk("R7 irq one edge after status", {7'd0, irq_out}, 8'h01);
        pins_in = 8'h00;
        idle(3);
        chk("R3 fall latches bit1, bit0 held", raw_stat, 8'h03);
        wr(3'd4, 8'h00);
        chk("R5 clear with zero data no effect", raw_stat, 8'h03);
        wr(3'd4, 8'h01);
        chk("R5 clear bit0 only", raw_stat, 8'h02);
        wr(3'd4, 8'h02);
        rd(3'd5, v);
        chk("R5 R8 raw readback after clear", v, 8'h00);
    endtask

    task automatic t_both;
        // bit2 both-edges in edge mode, bit3 both-edges in level mode
        wr(3'd0, 8'h08);
        wr(3'd1, 8'h0C);
        wr(3'd2, 8'h08);
        wr(3'd4, 8'hFF);
        pins_in = 8'h04;
        idle(3);
        chk("R4 both-edges rising with polarity 0", raw_stat & 8'h0C, 8'h04);
        wr(3'd4, 8'h04);
        pins_in = 8'h00;
        idle(3);
        chk("R4 both-edges falling", raw_stat & 8'h0C, 8'h04);
        pins_in = 8'h08;
        idle(2);
        chk("R4 both-edges ignored in level mode", raw_stat & 8'h0C, 8'h0C);
        pins_in = 8'h00;
        idle(2);
        chk("R4 level bit follows pin down", raw_stat & 8'h08, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'hFF);
        idle(2);
    endtask

    task automatic t_race;
        wr(3'd2, 8'h01);
        wr(3'd4, 8'hFF);
        pins_in = 8'h01;
        idle(3);
        chk("R3 bit0 set before race", raw_stat, 8'h01);
        pins_in = 8'h00;
        idle(3);
        pins_in = 8'h01;
        idle(2);
        wr(3'd4, 8'h01);
        chk("R5 edge wins over same-cycle clear", raw_stat, 8'h01);
        wr(3'd4, 8'h01);
        chk("R5 later clear works", raw_stat, 8'h00);
    endtask

    task automatic t_regmap;
        logic [W-1:0] v;
        wr(3'd3, 8'h01);
        pins_in = 8'h00;
        idle(3);
        pins_in = 8'h01;
        idle(3);
        rd(3'd6, v);
        chk("R8 masked readback", v, 8'h01);
        rd(3'd4, v);
        chk("R8 clear word reads zero", v, 8'h00);
        rd(3'd7, v);
        chk("R8 unused address reads zero", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_edge_rise_fall();
        t_both();
        t_race();
        t_regmap();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule